// File: doc/BRIEF.md
# Holdoff-Gated Ring Acquisition Controller

This controller runs a sample ring buffer that is written once per clock and stopped by a trigger. A start command opens an acquisition sequence. Writing restarts at address 0 and wraps through the ring without pause. For a programmable number of clocks after the start, the trigger input is ignored. Once that holdoff has elapsed, the first rising edge on the trigger input is accepted. Writing then goes on for a programmable number of further words and stops.

The trigger pin may change at any time, so it passes through a two-flop synchronizer and an edge detector. One controller serves every channel, because all channels share the trigger and must stop on the same word. When writing stops, the controller freezes the address it would have written next. That address holds the oldest word in the ring.

The two oldest words of the ring are unusable. The controller outputs the first usable address so that readout can begin there.

A post-trigger count of half the ring depth puts the trigger word near the middle of the stored window. A count larger than the ring depth pushes the trigger word out of the window, so the ring holds only samples taken after the trigger.

Top module: `acq_ring_ctrl`

## Requirements
- R1: After reset, `done` and `wr_en` are 0.
- R2: A `start` seen in the idle or finished state clears `done`. Writing begins on the next clock at address 0. Each following write uses the next address, modulo 128, and `wr_data` equals `sample_in` of that cycle.
- R3: A trigger rise is accepted only when the word it marks is written at least `pretrig`+2 clocks after the clock that sampled `start`. A trigger raised d clocks after that clock is therefore accepted if and only if d ≥ `pretrig`−1. An earlier rise is ignored.
- R4: The word marked as the trigger word is the one written on the third clock edge after `trig_async` rises. There are two synchronizer stages and one edge-detect stage.
- R5: After the trigger word, exactly `posttrig` further words are written. The newest stored word therefore holds the trigger word's sample plus `posttrig` clocks later.
- R6: A `posttrig` value of 0 behaves as 1.
- R7: After the last write, `done` goes to 1 and no further writes occur. `stop_ptr` equals the next address to write, which is the number of writes since start modulo 128. Both values hold until the next start.
- R8: `first_valid_ptr` equals `stop_ptr`+2 modulo 128.
- R9: A `start` during an active sequence is ignored. The write address is not reset.
- R10: Only a rising edge triggers. An input that is already high when holdoff ends does not trigger.
- R11: Only the first accepted edge of a sequence counts. A later edge during the post-trigger count does not extend the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin an acquisition sequence |
| trig_async | input | 1 | Asynchronous trigger, shared by all channels |
| pretrig | input | 16 | Holdoff length in clocks |
| posttrig | input | 16 | Words to write after the trigger word |
| sample_in | input | 32 | Incoming sample word |
| wr_en | output | 1 | Ring write strobe |
| wr_addr | output | 7 | Ring write address |
| wr_data | output | 32 | Ring write data |
| done | output | 1 | Acquisition finished |
| stop_ptr | output | 7 | Frozen address of the oldest word |
| first_valid_ptr | output | 7 | First usable address for readout |

## Verification
Each sample word carries the index of its clock. The newest stored word therefore shows exactly which clock the trigger was accepted on and how many words followed it.

Directed patterns cover the following cases:
- Trigger raised one clock before and exactly at the holdoff boundary. This separates an off-by-one in holdoff counting from correct gating.
- A trigger held high before start. This separates level detection from edge detection.
- A second pulse during the post-trigger count. This shows whether the count restarts.
- A start issued mid-sequence.
- A zero post-trigger count.
- A long count that wraps the ring and checks the oldest word.

Random holdoff, post-trigger and trigger-delay values then check the same relations across many combinations.

// File: rtl/acq_ring_ctrl.sv
module acq_ring_ctrl #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 128,
  parameter int CNT_W  = 16,
  parameter int GUARD  = 2,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              trig_async,
  input  logic [CNT_W-1:0]  pretrig,
  input  logic [CNT_W-1:0]  posttrig,
  input  logic [DATA_W-1:0] sample_in,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              done,
  output logic [AW-1:0]     stop_ptr,
  output logic [AW-1:0]     first_valid_ptr
);
  typedef enum logic [2:0] {S_IDLE, S_HOLD, S_ARM, S_POST, S_DONE} st_t;

  st_t              st;
  logic [2:0]       tsync;
  logic [CNT_W-1:0] cnt;
  logic [AW-1:0]    ptr, stop_q;

  wire              trig_edge = tsync[1] & ~tsync[2];
  wire [CNT_W-1:0]  post_eff  = (posttrig == '0) ? CNT_W'(1) : posttrig;

  assign wr_en           = (st == S_HOLD) || (st == S_ARM) || (st == S_POST);
  assign wr_addr         = ptr;
  assign wr_data         = sample_in;
  assign done            = (st == S_DONE);
  assign stop_ptr        = stop_q;
  assign first_valid_ptr = stop_q + AW'(GUARD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      tsync  <= '0;
      cnt    <= '0;
      ptr    <= '0;
      stop_q <= '0;
    end else begin
      tsync <= {tsync[1:0], trig_async};
      if (wr_en) ptr <= ptr + AW'(1);
      unique case (st)
        S_IDLE, S_DONE:
          if (start) begin
            st  <= S_HOLD;
            cnt <= '0;
            ptr <= '0;
          end
        S_HOLD:
          if (cnt == pretrig) st <= S_ARM;
          else                cnt <= cnt + CNT_W'(1);
        S_ARM:
          if (trig_edge) begin
            st  <= S_POST;
            cnt <= post_eff;
          end
        S_POST:
          if (cnt == CNT_W'(1)) begin
            st     <= S_DONE;
            stop_q <= ptr + AW'(1);
          end else cnt <= cnt - CNT_W'(1);
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module acq_ring_ctrl_chk #(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          done,
  input logic [AW-1:0] stop_ptr
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) $rose(rst_n) |-> !done && !wr_en);

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && $past(wr_en) |-> wr_addr == $past(wr_addr) + AW'(1));

  // R7
  no_write_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_en);

  // R7
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && $past(done) |-> $stable(stop_ptr));

  // R7
  stop_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(wr_en) && stop_ptr == $past(wr_addr) + AW'(1));
endmodule

bind acq_ring_ctrl acq_ring_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .done(done), .stop_ptr(stop_ptr)
);

// File: tb/sim_acq_ring_ctrl.sv
module sim_acq_ring_ctrl;
  logic clk = 0;
  always #2 clk = ~clk;

  logic        rst_n, start, trig;
  logic [15:0] pre, post;
  logic [31:0] smp;
  logic        wr_en, done;
  logic [6:0]  wr_addr, stop_ptr, first_valid_ptr;
  logic [31:0] wr_data;
  int          edge_n = 0;
  int          n_cmp = 0, n_bad = 0;

  assign smp = 32'(edge_n);

  acq_ring_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .trig_async(trig),
    .pretrig(pre), .posttrig(post), .sample_in(smp),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .stop_ptr(stop_ptr), .first_valid_ptr(first_valid_ptr)
  );

  always @(posedge clk) edge_n <= edge_n + 1;

  logic [31:0] mem [128];
  int nwr = 0, first_addr = -1, s_edge = 0;

  always @(negedge clk)
    if (wr_en) begin
      if (nwr == 0) first_addr = int'(wr_addr);
      if (wr_data != smp) begin
        n_bad++;
        $display("FAIL R2 wr_data act=%0d exp=%0d", wr_data, smp);
      end
      n_cmp++;
      mem[wr_addr] = wr_data;
      nwr++;
    end

  always @(posedge clk)
    if (edge_n > 150000) begin
      n_bad++;
      $display("FAIL watchdog act=%0d exp=<150000", edge_n);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end

  task automatic chk(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic begin_seq(int p, int n, bit clr);
    @(negedge clk);
    pre = 16'(p); post = 16'(n); start = 1;
    if (clr) begin nwr = 0; first_addr = -1; end
    s_edge = edge_n + 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic pulse_trig(output int k);
    trig = 1; k = edge_n;
    repeat (4) @(negedge clk);
    trig = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_done(int lim);
    for (int i = 0; i < lim && !done; i++) @(negedge clk);
  endtask

  task automatic check_result(string tag, int k, int n);
    int ne = (n == 0) ? 1 : n;
    chk({tag, " done"}, done, 1);
    chk({tag, " R5 newest"}, mem[7'(stop_ptr - 7'd1)], k + 2 + ne);
    chk({tag, " R7 stop_ptr"}, stop_ptr, nwr % 128);
    chk({tag, " R8 first_valid"}, first_valid_ptr, (stop_ptr + 2) % 128);
  endtask

  task automatic run(string tag, int p, int n, int d);
    int k;
    begin_seq(p, n, 1);
    while (edge_n < s_edge + d) @(negedge clk);
    pulse_trig(k);
    wait_done(n + 50);
    check_result(tag, k, n);
  endtask

  initial begin
    int k, sp, nw;
    process::self().srandom(32'd7341);
    rst_n = 0; start = 0; trig = 0; pre = 0; post = 1;
    repeat (3) @(negedge clk);
    chk("R1 done", done, 0);
    chk("R1 wr_en", wr_en, 0);
    rst_n = 1;

    run("R4 basic", 5, 6, 10);
    chk("R2 first addr", first_addr, 0);

    // R7: frozen after stop
    sp = stop_ptr; nw = nwr;
    repeat (10) @(negedge clk);
    chk("R7 writes after done", nwr, nw);
    chk("R7 stop stable", stop_ptr, sp);
    chk("R7 done held", done, 1);

    // R3: one clock too early is ignored, then a later edge is taken
    begin_seq(20, 8, 1);
    while (edge_n < s_edge + 18) @(negedge clk);
    pulse_trig(k);
    repeat (30) @(negedge clk);
    chk("R3 early ignored", done, 0);
    pulse_trig(k);
    wait_done(60);
    check_result("R3 late", k, 8);
    run("R3 boundary", 20, 8, 19);

    // R6: zero post count behaves as one
    run("R6 zero", 4, 0, 6);

    // R10: level already high is not a trigger
    trig = 1;
    repeat (4) @(negedge clk);
    begin_seq(5, 3, 1);
    repeat (40) @(negedge clk);
    chk("R10 level ignored", done, 0);
    trig = 0;
    repeat (3) @(negedge clk);
    pulse_trig(k);
    wait_done(40);
    check_result("R10", k, 3);

    // R11: second edge during post count
    begin_seq(2, 50, 1);
    repeat (8) @(negedge clk);
    pulse_trig(sp);
    pulse_trig(k);
    wait_done(100);
    check_result("R11", sp, 50);

    // R9: start mid-sequence ignored
    begin_seq(3, 10, 1);
    repeat (10) @(negedge clk);
    begin_seq(3, 10, 0);
    repeat (3) @(negedge clk);
    pulse_trig(k);
    wait_done(40);
    check_result("R9", k, 10);

    // R2: wrap of ring, oldest word
    run("R2 wrap", 2, 300, 5);
    chk("R2 oldest", mem[stop_ptr], mem[7'(stop_ptr - 7'd1)] - 127);

    for (int i = 0; i < 25; i++) begin
      int p = int'($urandom_range(0, 40));
      int n = int'($urandom_range(0, 200));
      int lo = (p > 0) ? p - 1 : 0;
      int d = lo + int'($urandom_range(0, 60));
      run("R5 random", p, n, d);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule